// File: doc/BRIEF.md
# Extension Instruction Execution Unit

This unit sits beside a 32-bit integer pipeline and runs a small group of extension instructions. There are three data rearrangements: a byte swap within each halfword, a halfword swap, and a full bit reverse. There is also a multiply with a narrow first operand, and a pair of operations that clear or set the interrupt-mask bit of the status word. Decode presents an opcode, two register operands and the current status word with a single-cycle start strobe.

The unit captures its result when it accepts the start. It then holds busy for the fixed latency of that operation. It presents the result, the register write enable and the updated status word together with a one-cycle done pulse. The multiply keeps bits 16..0 of the first operand and sign-extends bit 16. It multiplies this by the full signed second operand and returns the low 32 bits of the product as the new second register. It produces no high-word side result.

Top module: `ext_exec_unit`

## Requirements
- R1: Opcode 0 (byte swap) returns operand 2 with bytes 0 and 1 exchanged and bytes 2 and 3 exchanged, and asserts the register write enable.
- R2: Opcode 1 (halfword swap) returns operand 2 with its upper and lower 16 bits exchanged, and asserts the register write enable.
- R3: Opcode 2 (bit reverse) returns operand 2 with bit i moved to bit 31-i, and asserts the register write enable.
- R4: Opcode 3 (narrow multiply) returns the low 32 bits of the signed product of operand 2 and operand 1 sign-extended from bit 16. Bits 31..17 of operand 1 have no effect. The register write enable is asserted.
- R5: Opcode 4 clears and opcode 5 sets status bit 12 (mask 0x1000). All other status bits are unchanged and the register write enable stays low.
- R6: The done pulse comes exactly N cycles after the clock edge that accepts start, and lasts one cycle. N is 6 for byte swap, 1 for halfword swap, 22 for bit reverse, 9 for multiply and 12 for each status operation.
- R7: Busy is high from the cycle after an accepted start through the done cycle. A start seen while busy is high is ignored: the latency and result of the running operation are unchanged.
- R8: Outside the done cycle, result and write enable are zero and the status output equals the status input.
- R9: The swap results do not depend on operand 1.
- R10: A start with opcode 6 or 7 is not accepted: busy stays low and no done pulse follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start strobe |
| op_i | input | 3 | Operation select |
| src1_i | input | 32 | First register operand |
| src2_i | input | 32 | Second register operand |
| status_i | input | 32 | Current status word |
| result_o | output | 32 | Result, valid with done |
| wr_en_o | output | 1 | Register write enable, valid with done |
| status_o | output | 32 | Updated status word |
| busy_o | output | 1 | Operation in flight |
| done_o | output | 1 | Completion pulse |

## Verification
A wrong latency counter moves the done pulse by one or more cycles, or leaves busy stuck high. The bench counts cycles from the accepting edge on every operation, so this shows up on the first run of the affected opcode. A wrong capture or datapath slice corrupts the result in the done cycle of that same operation. The bench sweeps walking-one patterns through each rearrangement, so a single misplaced bit is caught. Status corruption outside bit 12, or a register write from a status operation, appears at the first status-operation done pulse.

// File: rtl/ext_exec_pkg.sv
package ext_exec_pkg;
  typedef enum logic [2:0] {
    OP_BSWAP     = 3'd0,
    OP_HSWAP     = 3'd1,
    OP_BREV      = 3'd2,
    OP_MULN      = 3'd3,
    OP_IMASK_CLR = 3'd4,
    OP_IMASK_SET = 3'd5,
    OP_RSV6      = 3'd6,
    OP_RSV7      = 3'd7
  } ext_op_e;

  function automatic logic op_valid(ext_op_e op);
    return op <= OP_IMASK_SET;
  endfunction

  function automatic logic op_is_status(ext_op_e op);
    return (op == OP_IMASK_CLR) || (op == OP_IMASK_SET);
  endfunction
endpackage

// File: rtl/ext_datapath.sv
module ext_datapath
  import ext_exec_pkg::*;
#(
  parameter int DW = 32,
  parameter int NW = 17,
  parameter int SB = 12
) (
  input  ext_op_e       op_i,
  input  logic [DW-1:0] src1_i,
  input  logic [DW-1:0] src2_i,
  input  logic [DW-1:0] status_i,
  output logic [DW-1:0] res_o,
  output logic          res_we_o,
  output logic [DW-1:0] status_o
);
  localparam int NHALF = DW / 16;

  logic [DW-1:0] brev, bsw, hsw, narrow_ext, mul_res;

  for (genvar i = 0; i < DW; i++) begin : g_brev
    assign brev[i] = src2_i[DW-1-i];
  end

  for (genvar h = 0; h < NHALF; h++) begin : g_bsw
    assign bsw[h*16 +: 8]     = src2_i[h*16+8 +: 8];
    assign bsw[h*16+8 +: 8]   = src2_i[h*16 +: 8];
  end

  assign hsw        = {src2_i[DW/2-1:0], src2_i[DW-1:DW/2]};
  assign narrow_ext = {{(DW-NW){src1_i[NW-1]}}, src1_i[NW-1:0]};
  // low word of product is sign-agnostic
  assign mul_res    = narrow_ext * src2_i;

  always_comb begin
    res_o    = '0;
    res_we_o = 1'b1;
    status_o = status_i;
    unique case (op_i)
      OP_BSWAP:     res_o = bsw;
      OP_HSWAP:     res_o = hsw;
      OP_BREV:      res_o = brev;
      OP_MULN:      res_o = mul_res;
      OP_IMASK_CLR: begin res_we_o = 1'b0; status_o[SB] = 1'b0; end
      OP_IMASK_SET: begin res_we_o = 1'b0; status_o[SB] = 1'b1; end
      default:      res_we_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/ext_seq_ctl.sv
module ext_seq_ctl #(
  parameter int CW = 5
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          launch_i,
  input  logic [CW-1:0] lat_m1_i,
  output logic          busy_o,
  output logic          done_o
);
  logic          busy_q;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (!busy_q) begin
      if (launch_i) begin
        busy_q <= 1'b1;
        cnt_q  <= lat_m1_i;
      end
    end else if (cnt_q == '0) begin
      busy_q <= 1'b0;
    end else begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign busy_o = busy_q;
  assign done_o = busy_q && (cnt_q == '0);

  a_r6_count_down: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && cnt_q != '0) |=> (busy_q && cnt_q == $past(cnt_q) - 1'b1));
  a_r6_done_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  a_r7_launch_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (launch_i && !busy_q) |=> busy_q);
  a_r7_hold_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && !done_o) |=> busy_q);
endmodule

// File: rtl/ext_exec_unit.sv
module ext_exec_unit
  import ext_exec_pkg::*;
#(
  parameter int DW         = 32,
  parameter int NW         = 17,
  parameter int SB         = 12,
  parameter int LAT_BSWAP  = 6,
  parameter int LAT_HSWAP  = 1,
  parameter int LAT_BREV   = 22,
  parameter int LAT_MULN   = 9,
  parameter int LAT_STATUS = 12
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [2:0]    op_i,
  input  logic [DW-1:0] src1_i,
  input  logic [DW-1:0] src2_i,
  input  logic [DW-1:0] status_i,
  output logic [DW-1:0] result_o,
  output logic          wr_en_o,
  output logic [DW-1:0] status_o,
  output logic          busy_o,
  output logic          done_o
);
  function automatic int imax(int a, int b);
    return (a > b) ? a : b;
  endfunction

  localparam int LAT_MAX = imax(imax(imax(LAT_BSWAP, LAT_HSWAP), imax(LAT_BREV, LAT_MULN)),
                                LAT_STATUS);
  localparam int CW = (LAT_MAX > 1) ? $clog2(LAT_MAX) : 1;

  ext_op_e       op;
  logic          launch;
  logic [CW-1:0] lat_m1;
  logic [DW-1:0] dp_res, dp_status;
  logic          dp_we;

  logic [DW-1:0] res_q, stat_q, stat_in_q;
  logic          we_q;
  ext_op_e       op_q;

  assign op     = ext_op_e'(op_i);
  assign launch = start_i && !busy_o && op_valid(op);

  always_comb begin
    unique case (op)
      OP_BSWAP:                   lat_m1 = CW'(LAT_BSWAP - 1);
      OP_HSWAP:                   lat_m1 = CW'(LAT_HSWAP - 1);
      OP_BREV:                    lat_m1 = CW'(LAT_BREV - 1);
      OP_MULN:                    lat_m1 = CW'(LAT_MULN - 1);
      OP_IMASK_CLR, OP_IMASK_SET: lat_m1 = CW'(LAT_STATUS - 1);
      default:                    lat_m1 = '0;
    endcase
  end

  ext_datapath #(.DW(DW), .NW(NW), .SB(SB)) u_dp (
    .op_i     (op),
    .src1_i   (src1_i),
    .src2_i   (src2_i),
    .status_i (status_i),
    .res_o    (dp_res),
    .res_we_o (dp_we),
    .status_o (dp_status)
  );

  ext_seq_ctl #(.CW(CW)) u_ctl (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .launch_i (launch),
    .lat_m1_i (lat_m1),
    .busy_o   (busy_o),
    .done_o   (done_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      res_q     <= '0;
      we_q      <= 1'b0;
      stat_q    <= '0;
      stat_in_q <= '0;
      op_q      <= OP_BSWAP;
    end else if (launch) begin
      res_q     <= dp_res;
      we_q      <= dp_we;
      stat_q    <= dp_status;
      stat_in_q <= status_i;
      op_q      <= op;
    end
  end

  assign result_o = done_o ? res_q : '0;
  assign wr_en_o  = done_o && we_q;
  assign status_o = done_o ? stat_q : status_i;

  a_r5_other_bits: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (((status_o ^ stat_in_q) & ~(DW'(1) << SB)) == '0));
  a_r5_no_regwrite: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && op_is_status(op_q)) |-> !wr_en_o);
  a_r8_quiet_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> (!wr_en_o && result_o == '0 && status_o == status_i));
  a_r10_reserved: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_o && !op_valid(op)) |=> !busy_o);
  a_r6_done_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !busy_o);
endmodule

// File: tb/ext_exec_unit_test.sv
module ext_exec_unit_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [2:0]  op = '0;
  logic [31:0] s1 = '0, s2 = '0, st = '0;
  logic [31:0] result, status;
  logic        wr_en, busy, done;

  int n_chk = 0, n_fail = 0;
  logic [31:0] rng = 32'h1357_9BDF;

  always #4 clk = ~clk;

  ext_exec_unit uut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .op_i(op),
    .src1_i(s1), .src2_i(s2), .status_i(st),
    .result_o(result), .wr_en_o(wr_en), .status_o(status),
    .busy_o(busy), .done_o(done)
  );

  task automatic chk(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] nxt(input logic [31:0] x);
    logic [31:0] y = x;
    y ^= y << 13; y ^= y >> 17; y ^= y << 5;
    return y;
  endfunction

  function automatic int exp_lat(input logic [2:0] o);
    case (o)
      3'd0: return 6;
      3'd1: return 1;
      3'd2: return 22;
      3'd3: return 9;
      default: return 12;
    endcase
  endfunction

  function automatic logic [31:0] exp_res(input logic [2:0] o, input logic [31:0] a, input logic [31:0] b);
    logic [31:0] r = '0;
    logic signed [31:0] ea;
    case (o)
      3'd0: r = ((b & 32'h00FF00FF) << 8) | ((b >> 8) & 32'h00FF00FF);
      3'd1: r = (b << 16) | (b >> 16);
      3'd2: for (int i = 0; i < 32; i++) r |= ((b >> i) & 32'd1) << (31 - i);
      3'd3: begin
        ea = $signed(a << 15) >>> 15;
        r  = 32'(ea * $signed(b));
      end
      default: r = '0;
    endcase
    return r;
  endfunction

  // inj: issue a competing start while busy (R7)
  task automatic run(input logic [2:0] o, input logic [31:0] a, input logic [31:0] b,
                     input logic [31:0] s, input logic inj, input string tag);
    int cyc;
    logic [31:0] es;
    @(negedge clk);
    op = o; s1 = a; s2 = b; st = s; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    cyc = 1;
    chk(busy, "R7 busy after start", {31'd0, busy}, 32'd1);
    while (!done && cyc < 40) begin
      if (inj && cyc == 2) begin
        start = 1'b1; op = 3'd1; s2 = ~b; s1 = ~a;
      end else if (inj && cyc == 3) begin
        start = 1'b0; s2 = b; s1 = a; op = o;
      end
      chk(busy, "R7 busy held", {31'd0, busy}, 32'd1);
      @(negedge clk);
      cyc++;
    end
    start = 1'b0;
    chk(cyc == exp_lat(o), {"R6 latency ", tag}, cyc, exp_lat(o));
    if (o >= 3'd4) begin
      es = (o == 3'd4) ? (s & ~32'h1000) : (s | 32'h1000);
      chk(status == es, {"R5 status ", tag}, status, es);
      chk(!wr_en, {"R5 no write ", tag}, {31'd0, wr_en}, 32'd0);
    end else begin
      chk(result == exp_res(o, a, b), {tag, " result"}, result, exp_res(o, a, b));
      chk(wr_en, {tag, " write enable"}, {31'd0, wr_en}, 32'd1);
    end
    @(negedge clk);
    chk(!done && !busy, "R6 single done pulse", {30'd0, done, busy}, 32'd0);
    chk(!wr_en && result == 0 && status == st, "R8 idle outputs", result, 32'd0);
  endtask

  initial begin
    #400000;
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=%0d expected=0", 1);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    st = 32'hA5A5_5A5A;
    repeat (3) @(negedge clk);
    chk(!busy && !done && !wr_en && result == 0, "R8 reset state", result, 32'd0);
    chk(status == st, "R8 reset status passthrough", status, st);
    rst_n = 1'b1;

    for (int i = 0; i < 32; i++) begin
      run(3'd0, 32'hFFFF_0000 ^ i, 32'd1 << i, 32'h0, 1'b0, "R1");
      run(3'd2, 32'h0, 32'd1 << i, 32'h0, 1'b0, "R3");
      run(3'd1, rng, 32'd1 << i, 32'h0, 1'b0, "R2");
      rng = nxt(rng);
    end
    for (int i = 0; i < 8; i++) begin
      run(3'd0, rng, 32'h1234_ABCD ^ (i * 32'h1111_1111), 32'h0, 1'b0, "R9 bswap");
      rng = nxt(rng);
      run(3'd1, rng, 32'hDEAD_BEEF + i, 32'h0, 1'b0, "R9 hswap");
      rng = nxt(rng);
    end

    run(3'd3, 32'h0000_FFFF, 32'h0000_0003, 32'h0, 1'b0, "R4 pos max");
    run(3'd3, 32'h0001_0000, 32'h0000_0003, 32'h0, 1'b0, "R4 neg min");
    run(3'd3, 32'h0001_FFFF, 32'h8000_0000, 32'h0, 1'b0, "R4 minus one");
    run(3'd3, 32'hFFFE_0002, 32'h7FFF_FFFF, 32'h0, 1'b0, "R4 upper ignored");
    run(3'd3, 32'h0002_0005, 32'hFFFF_FFF0, 32'h0, 1'b0, "R4 bit17 ignored");
    for (int i = 0; i < 24; i++) begin
      logic [31:0] a;
      a = rng; rng = nxt(rng);
      run(3'd3, a, rng, 32'h0, 1'b0, "R4 sweep");
      rng = nxt(rng);
    end

    run(3'd4, 32'h0, 32'h0, 32'hFFFF_FFFF, 1'b0, "clr ones");
    run(3'd4, 32'h0, 32'h0, 32'h0000_0000, 1'b0, "clr zero");
    run(3'd5, 32'h0, 32'h0, 32'h0000_0000, 1'b0, "set zero");
    run(3'd5, 32'h0, 32'h0, 32'h5A5A_A5A5, 1'b0, "set pattern");
    run(3'd4, 32'h0, 32'h0, 32'h1234_5678, 1'b0, "clr pattern");

    run(3'd2, 32'h0, 32'h8001_0F30, 32'h0, 1'b1, "R7 ignore start brev");
    run(3'd3, 32'h0001_2345, 32'h0000_0777, 32'h0, 1'b1, "R7 ignore start mul");

    for (int o = 6; o < 8; o++) begin
      @(negedge clk);
      op = 3'(o); start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      for (int k = 0; k < 4; k++) begin
        chk(!busy && !done, "R10 reserved opcode ignored", {30'd0, busy, done}, 32'd0);
        @(negedge clk);
      end
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule